// File: doc/BRIEF.md
# Indirect Redirection-Table Register Front End

This block is the register front end of an interrupt router. Software sees only two memory-mapped registers: a select register and a data window. The value written into the select register chooses what the window reaches. That can be a 4-bit identification value, a read-only version word, or one half of a 64-bit redirection entry. There is one entry per input pin. Bus accesses may be 1, 2, 4 or 8 bytes wide. Only the low 8 address bits are decoded.

Each entry has these fields, at the positions below:

| Bits | Field |
|------|-------|
| 7:0 | vector |
| 10:8 | delivery kind |
| 11 | destination addressing |
| 13 | input polarity |
| 14 | remote-IRR |
| 15 | trigger (1 = level) |
| 16 | mask |
| 63:56 | destination |

The block keeps a registered IRR bit per pin. That bit is the pin level XOR the entry's polarity bit.

The block raises two pulses. The first reports a changed mask bit. The second requests service of a pin when a table write leaves that pin level-triggered, unmasked and with its IRR bit set. Delivery itself happens outside the block. When the block raises a service request, it also marks the entry's remote-IRR bit. Read data returns one cycle after the request.

Top module: `irq_route_regs`

## Requirements
- R1: A write to offset 0x00 stores the low byte of the 32-bit write value in the 8-bit select register. A read of offset 0x00 returns the select value zero-extended. The select value is 0 after reset.
- R2: With select 0x01, the window reads `{8'h00, NPINS-1 [7:0], 8'h00, VERSION}`. Writes through the window with select 0x01 change nothing.
- R3: With select 0x00, a window write stores write-value bits 27:24 as the ID. The window then reads the ID in bits 27:24 and zeros elsewhere. Select 0x02 reads the same word, and window writes with select 0x02 change nothing. The ID is 0 after reset.
- R4: For a select of 0x10 or above, the entry index is (select - 0x10) >> 1. An odd select reaches entry bits 63:32 and an even select reaches bits 31:0. A write replaces only the selected half.
- R5: If the computed index is at or past NPINS, or the select is 0x03 to 0x0F, the window reads 32'hFFFF_FFFF and a window write changes no state and raises no pulse.
- R6: A write to the low half of an entry forces remote-IRR (bit 14) to 0. The exception is a write that raises a service request (R8).
- R7: One cycle after a table write that changes mask bit 16, `mask_evt` is high for one cycle. `mask_pin` then carries the index and `mask_val` carries the new mask. If the mask is unchanged, no pulse appears.
- R8: One cycle after a table write, `svc_req` pulses with `svc_pin` if the written entry has trigger bit 15 = 1, mask bit 16 = 0, and the pin's IRR bit set. The same write leaves remote-IRR = 1. An edge-triggered or masked entry gets no service request.
- R9: Each clock, a pin's IRR bit is loaded with `pin_level` XOR the entry's polarity bit 13. All IRR bits are 0 after reset.
- R10: After reset, every entry reads 64'h0000_0000_0001_0000, which means only the mask bit is set.
- R11: Low address bits other than 0x00 and 0x10 read 0 and ignore writes. Address bits above bit 7 are ignored.
- R12: `req_size` 0, 1, 2, 3 selects 1, 2, 4 or 8 bytes. A narrow write zero-extends data bits 7:0 or 15:0 to the 32-bit write value, and 4- and 8-byte writes use bits 31:0. A read truncates the 32-bit value to the access size, and an 8-byte read zero-extends it to 64 bits.
- R13: `rd_valid` is high exactly one cycle after a read request and carries `rd_data` for it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Bus request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address; only bits 7:0 decoded |
| req_size | input | 2 | Access size code (R12) |
| req_wdata | input | 64 | Write data |
| pin_level | input | NPINS | Raw input pin levels |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 64 | Read data |
| mask_evt | output | 1 | Mask-change pulse |
| mask_pin | output | PIN_W | Pin whose mask changed |
| mask_val | output | 1 | New mask value |
| svc_req | output | 1 | Service request pulse |
| svc_pin | output | PIN_W | Pin to service |

## Verification
A single low-half write can clear remote-IRR and also raise a service request that sets remote-IRR again. In that same cycle, unmasking the entry also produces a mask-change pulse. The bench provokes this by holding a pin's level high and then writing an unmasked, level-triggered low half to that pin's entry. It then checks that both pulses rise in the same cycle with the right pin, and that the entry reads back with remote-IRR set. A masked low write is then made to the same entry after the level drops. It must produce a mask pulse, no service request, and remote-IRR cleared.

// File: rtl/irq_rr_pkg.sv
package irq_rr_pkg;
  localparam int F_POL  = 13;
  localparam int F_RIRR = 14;
  localparam int F_TRIG = 15;
  localparam int F_MASK = 16;

  localparam logic [7:0] OFS_SEL = 8'h00;
  localparam logic [7:0] OFS_WIN = 8'h10;

  localparam logic [7:0] SEL_ID  = 8'h00;
  localparam logic [7:0] SEL_VER = 8'h01;
  localparam logic [7:0] SEL_ARB = 8'h02;
  localparam logic [7:0] SEL_TBL = 8'h10;

  localparam logic [63:0] ENTRY_RST = 64'h0000_0000_0001_0000;

  typedef enum logic [1:0] {
    SZ_1B = 2'd0,
    SZ_2B = 2'd1,
    SZ_4B = 2'd2,
    SZ_8B = 2'd3
  } acc_size_e;
endpackage

// File: rtl/irq_rr_rst_sync.sv
module irq_rr_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage_q <= 2'b00;
    else         stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_o = stage_q[1];
endmodule

// File: rtl/irq_rr_lanes.sv
module irq_rr_lanes
  import irq_rr_pkg::*;
(
  input  acc_size_e   size_i,
  input  logic [63:0] wdata_i,
  input  logic [31:0] rval_i,
  output logic [31:0] wval_o,
  output logic [63:0] rdata_o
);
  logic unused_hi;
  assign unused_hi = ^wdata_i[63:32];

  always_comb begin
    case (size_i)
      SZ_1B: begin
        wval_o  = {24'h0, wdata_i[7:0]};
        rdata_o = {56'h0, rval_i[7:0]};
      end
      SZ_2B: begin
        wval_o  = {16'h0, wdata_i[15:0]};
        rdata_o = {48'h0, rval_i[15:0]};
      end
      default: begin
        wval_o  = wdata_i[31:0];
        rdata_o = {32'h0, rval_i};
      end
    endcase
  end
endmodule

// File: rtl/irq_rr_entry.sv
module irq_rr_entry
  import irq_rr_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en_i,
  input  logic        wr_hi_i,
  input  logic [31:0] wval_i,
  input  logic        irr_i,
  output logic [63:0] ent_o,
  output logic        mask_chg_o,
  output logic        mask_new_o,
  output logic        svc_o
);
  logic [63:0] ent_q;
  logic [63:0] merged;
  logic [63:0] ent_d;

  always_comb begin
    merged = ent_q;
    if (wr_hi_i) begin
      merged[63:32] = wval_i;
    end else begin
      merged[31:0]  = wval_i;
      merged[F_RIRR] = 1'b0;
    end
    svc_o      = wr_en_i && merged[F_TRIG] && !merged[F_MASK] && irr_i;
    mask_chg_o = wr_en_i && (merged[F_MASK] != ent_q[F_MASK]);
    mask_new_o = merged[F_MASK];
    ent_d      = merged;
    if (svc_o) ent_d[F_RIRR] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ent_q <= ENTRY_RST;
    else if (wr_en_i) ent_q <= ent_d;
  end

  assign ent_o = ent_q;
endmodule

// File: rtl/irq_route_regs.sv
module irq_route_regs
  import irq_rr_pkg::*;
#(
  parameter int         NPINS   = 24,
  parameter int         ADDR_W  = 12,
  parameter logic [7:0] VERSION = 8'h11,
  localparam int        PIN_W   = (NPINS > 1) ? $clog2(NPINS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic [63:0]       req_wdata,
  input  logic [NPINS-1:0]  pin_level,
  output logic              rd_valid,
  output logic [63:0]       rd_data,
  output logic              mask_evt,
  output logic [PIN_W-1:0]  mask_pin,
  output logic              mask_val,
  output logic              svc_req,
  output logic [PIN_W-1:0]  svc_pin
);
  localparam logic [7:0] MAX_PIN = 8'(NPINS - 1);

  logic rst_sync_n;
  irq_rr_rst_sync u_rst (.clk(clk), .arst_n(rst_n), .rst_n_o(rst_sync_n));

  logic [7:0] ofs;
  logic       is_sel, is_win;
  logic       unused_addr;
  assign ofs    = req_addr[7:0];
  assign is_sel = (ofs == OFS_SEL);
  assign is_win = (ofs == OFS_WIN);
  generate
    if (ADDR_W > 8) begin : g_hi_addr
      assign unused_addr = ^req_addr[ADDR_W-1:8];
    end else begin : g_no_hi_addr
      assign unused_addr = 1'b0;
    end
  endgenerate

  logic [7:0] sel_q, sel_d;
  logic [3:0] id_q, id_d;
  logic [NPINS-1:0] irr_q, irr_d;
  logic        rd_valid_q;
  logic [63:0] rd_data_q;
  logic        mask_evt_q, mask_val_q, svc_q;
  logic [PIN_W-1:0] mask_pin_q, svc_pin_q;

  logic [31:0] wval;
  logic [31:0] rval;
  logic [63:0] rdata_fmt;

  irq_rr_lanes u_lanes (
    .size_i (acc_size_e'(req_size)),
    .wdata_i(req_wdata),
    .rval_i (rval),
    .wval_o (wval),
    .rdata_o(rdata_fmt)
  );

  logic [7:0]       idx_full;
  logic             idx_ok;
  logic [PIN_W-1:0] idx_sel;
  assign idx_full = (sel_q - SEL_TBL) >> 1;
  assign idx_ok   = (sel_q >= SEL_TBL) && ({24'h0, idx_full} < 32'(NPINS));
  assign idx_sel  = idx_ok ? idx_full[PIN_W-1:0] : '0;

  logic wr_req, rd_req, win_wr;
  assign wr_req = req_valid && req_write;
  assign rd_req = req_valid && !req_write;
  assign win_wr = wr_req && is_win;

  logic [63:0]      ent_q [NPINS];
  logic [NPINS-1:0] ent_wr, chg_vec, newm_vec, svc_vec;

  generate
    for (genvar i = 0; i < NPINS; i++) begin : g_ent
      assign ent_wr[i] = win_wr && idx_ok && (idx_sel == PIN_W'(i));
      irq_rr_entry u_ent (
        .clk       (clk),
        .rst_n     (rst_sync_n),
        .wr_en_i   (ent_wr[i]),
        .wr_hi_i   (sel_q[0]),
        .wval_i    (wval),
        .irr_i     (irr_q[i]),
        .ent_o     (ent_q[i]),
        .mask_chg_o(chg_vec[i]),
        .mask_new_o(newm_vec[i]),
        .svc_o     (svc_vec[i])
      );
      assign irr_d[i] = pin_level[i] ^ ent_q[i][F_POL];
    end
  endgenerate

  logic [31:0] win_val;
  always_comb begin
    case (sel_q)
      SEL_ID, SEL_ARB: win_val = {4'h0, id_q, 24'h0};
      SEL_VER:         win_val = {8'h00, MAX_PIN, 8'h00, VERSION};
      default: begin
        if (idx_ok) win_val = sel_q[0] ? ent_q[idx_sel][63:32] : ent_q[idx_sel][31:0];
        else        win_val = 32'hFFFF_FFFF;
      end
    endcase
  end

  always_comb begin
    if (is_sel)      rval = {24'h0, sel_q};
    else if (is_win) rval = win_val;
    else             rval = 32'h0;
  end

  logic evt_any, evt_val, svc_any;
  always_comb begin
    evt_any = |chg_vec;
    svc_any = |svc_vec;
    evt_val = 1'b0;
    for (int i = 0; i < NPINS; i++) begin
      if (chg_vec[i]) evt_val = newm_vec[i];
    end
  end

  always_comb begin
    sel_d = sel_q;
    id_d  = id_q;
    if (wr_req && is_sel) sel_d = wval[7:0];
    if (win_wr && (sel_q == SEL_ID)) id_d = wval[27:24];
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      sel_q      <= '0;
      id_q       <= '0;
      irr_q      <= '0;
      rd_valid_q <= 1'b0;
      rd_data_q  <= '0;
      mask_evt_q <= 1'b0;
      mask_val_q <= 1'b0;
      mask_pin_q <= '0;
      svc_q      <= 1'b0;
      svc_pin_q  <= '0;
    end else begin
      sel_q      <= sel_d;
      id_q       <= id_d;
      irr_q      <= irr_d;
      rd_valid_q <= rd_req;
      if (rd_req) rd_data_q <= rdata_fmt;
      mask_evt_q <= evt_any;
      svc_q      <= svc_any;
      if (evt_any) begin
        mask_pin_q <= idx_sel;
        mask_val_q <= evt_val;
      end
      if (svc_any) svc_pin_q <= idx_sel;
    end
  end

  assign rd_valid = rd_valid_q;
  assign rd_data  = rd_data_q;
  assign mask_evt = mask_evt_q;
  assign mask_pin = mask_pin_q;
  assign mask_val = mask_val_q;
  assign svc_req  = svc_q;
  assign svc_pin  = svc_pin_q;
endmodule

// File: rtl/irq_route_regs_chk.sv
module irq_route_regs_chk #(
  parameter int NPINS  = 24,
  parameter int ADDR_W = 12,
  parameter int PIN_W  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic              rd_valid,
  input logic [63:0]       rd_data,
  input logic              mask_evt,
  input logic              svc_req,
  input logic [PIN_W-1:0]  svc_pin
);
  assert_rd_origin_R13: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(req_valid && !req_write));

  assert_rd_follows_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rd_valid);

  assert_mask_src_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mask_evt |-> $past(req_valid && req_write && (req_addr[7:0] == 8'h10)));

  assert_svc_src_R8: assert property (@(posedge clk) disable iff (!rst_n)
    svc_req |-> $past(req_valid && req_write && (req_addr[7:0] == 8'h10)));

  assert_svc_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    svc_req |-> (32'(svc_pin) < NPINS));

  assert_other_ofs_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && $past(req_addr[7:0] != 8'h00 && req_addr[7:0] != 8'h10)) |-> (rd_data == 64'h0));
endmodule

bind irq_route_regs irq_route_regs_chk #(.NPINS(NPINS), .ADDR_W(ADDR_W), .PIN_W(PIN_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .req_valid(req_valid),
  .req_write(req_write),
  .req_addr (req_addr),
  .rd_valid (rd_valid),
  .rd_data  (rd_data),
  .mask_evt (mask_evt),
  .svc_req  (svc_req),
  .svc_pin  (svc_pin)
);

// File: tb/tb_irq_route_regs.sv
module tb_irq_route_regs;
  localparam int NP = 24;
  localparam int AW = 12;
  localparam int PW = 5;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid, req_write;
  logic [AW-1:0] req_addr;
  logic [1:0]    req_size;
  logic [63:0]   req_wdata;
  logic [NP-1:0] pin_level;
  logic          rd_valid;
  logic [63:0]   rd_data;
  logic          mask_evt, mask_val, svc_req;
  logic [PW-1:0] mask_pin, svc_pin;

  always #5 clk = ~clk;

  irq_route_regs #(.NPINS(NP), .ADDR_W(AW), .VERSION(8'h11)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .pin_level(pin_level), .rd_valid(rd_valid), .rd_data(rd_data),
    .mask_evt(mask_evt), .mask_pin(mask_pin), .mask_val(mask_val),
    .svc_req(svc_req), .svc_pin(svc_pin)
  );

  int total = 0;
  int bad = 0;
  bit done = 0;
  logic [63:0] q_exp[$];
  string       q_tag[$];

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (q_exp.size() == 0) begin
        chk(1'b0, "R13 read data with no request", rd_data, 64'h0);
      end else begin
        logic [63:0] e;
        string t;
        e = q_exp.pop_front();
        t = q_tag.pop_front();
        chk(rd_data == e, t, rd_data, e);
      end
    end
  end

  task automatic rd(input logic [AW-1:0] a, input logic [1:0] sz, input logic [63:0] e, input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_size = sz;
    q_exp.push_back(e);
    q_tag.push_back(tag);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [1:0] sz, input logic [63:0] d,
                    input bit em, input logic [PW-1:0] mp, input bit mv,
                    input bit es, input logic [PW-1:0] sp, input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_size = sz; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    chk(mask_evt == em, {tag, " R7 mask pulse"}, 64'(mask_evt), 64'(em));
    if (em) begin
      chk(mask_pin == mp, {tag, " R7 mask pin"}, 64'(mask_pin), 64'(mp));
      chk(mask_val == mv, {tag, " R7 mask value"}, 64'(mask_val), 64'(mv));
    end
    chk(svc_req == es, {tag, " R8 service pulse"}, 64'(svc_req), 64'(es));
    if (es) chk(svc_pin == sp, {tag, " R8 service pin"}, 64'(svc_pin), 64'(sp));
  endtask

  task automatic selw(input logic [7:0] s);
    wr(12'h000, 2'd2, {56'h0, s}, 1'b0, '0, 1'b0, 1'b0, '0, "R1 select write");
  endtask

  task automatic winw(input logic [31:0] d, input bit em, input logic [PW-1:0] mp, input bit mv,
                      input bit es, input logic [PW-1:0] sp, input string tag);
    wr(12'h010, 2'd2, {32'h0, d}, em, mp, mv, es, sp, tag);
  endtask

  task automatic winr(input logic [31:0] e, input string tag);
    rd(12'h010, 2'd2, {32'h0, e}, tag);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary;
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0;
    req_size = 2'd2; req_wdata = '0; pin_level = '0;
    idle(4);
    rst_n = 1'b1;
    idle(4);

    rd(12'h000, 2'd2, 64'h0, "R1 select after reset");
    selw(8'h10); winr(32'h0001_0000, "R10 entry0 low after reset");
    selw(8'h11); winr(32'h0, "R10 entry0 high after reset");
    selw(8'h3E); winr(32'h0001_0000, "R10 last entry after reset");
    selw(8'h00); winr(32'h0, "R3 ID after reset");

    wr(12'h000, 2'd2, 64'h1FF, 1'b0, '0, 1'b0, 1'b0, '0, "R1 wide select write");
    rd(12'h000, 2'd2, 64'hFF, "R1 select keeps low byte");
    wr(12'h000, 2'd0, 64'h1234, 1'b0, '0, 1'b0, 1'b0, '0, "R12 byte select write");
    rd(12'h000, 2'd3, 64'h34, "R12 byte write zero-extends");

    selw(8'h01); winr(32'h0017_0011, "R2 version");
    winw(32'hFFFF_FFFF, 1'b0, '0, 1'b0, 1'b0, '0, "R2 version write");
    winr(32'h0017_0011, "R2 version write ignored");

    selw(8'h00);
    winw(32'hA500_0000, 1'b0, '0, 1'b0, 1'b0, '0, "R3 ID write");
    winr(32'h0500_0000, "R3 ID readback");
    selw(8'h02); winr(32'h0500_0000, "R3 arbitration select mirrors ID");
    winw(32'h0F00_0000, 1'b0, '0, 1'b0, 1'b0, '0, "R3 arbitration write");
    selw(8'h00); winr(32'h0500_0000, "R3 arbitration write ignored");

    selw(8'h16);
    winw(32'h0000_8031, 1'b1, PW'(3), 1'b0, 1'b0, '0, "R4 entry3 low write");
    winr(32'h0000_8031, "R4 entry3 low readback");
    selw(8'h17);
    winw(32'hAB00_0000, 1'b0, '0, 1'b0, 1'b0, '0, "R4 entry3 high write");
    winr(32'hAB00_0000, "R4 entry3 high readback");
    selw(8'h16); winr(32'h0000_8031, "R4 low half untouched by high write");

    pin_level[5] = 1'b1; idle(3);
    selw(8'h1A);
    winw(32'h0000_8040, 1'b1, PW'(5), 1'b0, 1'b1, PW'(5), "R8 unmask level pin5 with IRR");
    winr(32'h0000_C040, "R8 remote-IRR set by service");
    selw(8'h1B);
    winw(32'h1200_0000, 1'b0, '0, 1'b0, 1'b1, PW'(5), "R8 high write services pin5");
    winr(32'h1200_0000, "R4 pin5 high readback");
    selw(8'h1A); winr(32'h0000_C040, "R6 high write keeps remote-IRR");
    pin_level[5] = 1'b0; idle(3);
    winw(32'h0001_8040, 1'b1, PW'(5), 1'b1, 1'b0, '0, "R6 masked low write pin5");
    winr(32'h0001_8040, "R6 remote-IRR cleared");

    selw(8'h1E);
    winw(32'h0001_4022, 1'b0, '0, 1'b0, 1'b0, '0, "R6 low write with bit14");
    winr(32'h0001_0022, "R6 bit14 forced to zero");

    selw(8'h22);
    winw(32'h0000_A050, 1'b1, PW'(9), 1'b0, 1'b0, '0, "R9 pin9 active-low setup");
    idle(2);
    selw(8'h23);
    winw(32'h0000_0000, 1'b0, '0, 1'b0, 1'b1, PW'(9), "R9 inverted polarity makes IRR set");
    selw(8'h22); winr(32'h0000_E050, "R9 pin9 remote-IRR set");

    pin_level[11] = 1'b1; idle(3);
    selw(8'h26);
    winw(32'h0000_0060, 1'b1, PW'(11), 1'b0, 1'b0, '0, "R8 edge entry no service");
    winr(32'h0000_0060, "R8 edge entry readback");

    selw(8'h40); winr(32'hFFFF_FFFF, "R5 index past end low");
    winw(32'h0, 1'b0, '0, 1'b0, 1'b0, '0, "R5 write past end dropped");
    selw(8'h41); winr(32'hFFFF_FFFF, "R5 index past end high");
    selw(8'h05); winr(32'hFFFF_FFFF, "R5 select 0x05 all ones");
    winw(32'h0, 1'b0, '0, 1'b0, 1'b0, '0, "R5 write select 0x05 dropped");
    selw(8'h3E); winr(32'h0001_0000, "R5 last entry untouched");
    selw(8'h00); winr(32'h0500_0000, "R5 ID untouched");

    selw(8'h01);
    rd(12'h020, 2'd2, 64'h0, "R11 other offset reads zero");
    wr(12'h020, 2'd2, 64'h77, 1'b0, '0, 1'b0, 1'b0, '0, "R11 other offset write");
    rd(12'h000, 2'd2, 64'h01, "R11 write elsewhere ignored");
    rd(12'h110, 2'd2, 64'h0017_0011, "R11 upper address bits ignored");
    rd(12'h004, 2'd2, 64'h0, "R11 offset 0x04 reads zero");

    rd(12'h010, 2'd0, 64'h11, "R12 byte read");
    rd(12'h010, 2'd1, 64'h0011, "R12 halfword read");
    rd(12'h010, 2'd3, 64'h0000_0000_0017_0011, "R12 doubleword read zero-extended");
    selw(8'h10);
    wr(12'h010, 2'd1, 64'hFFFF_1234, 1'b1, PW'(0), 1'b0, 1'b0, '0, "R12 halfword entry write");
    winr(32'h0000_1234, "R12 halfword write zero-extended");
    wr(12'h010, 2'd3, 64'hDEAD_BEEF_0001_0000, 1'b1, PW'(0), 1'b1, 1'b0, '0, "R12 doubleword entry write");
    winr(32'h0001_0000, "R12 doubleword write uses low 32 bits");
    selw(8'h11); winr(32'h0, "R12 doubleword write leaves high half");

    idle(3);
    chk(q_exp.size() == 0, "R13 all reads returned", 64'(q_exp.size()), 64'h0);
    done = 1;
    summary();
    $finish;
  end
endmodule